// File: doc/BRIEF.md
# Two-Wire Converter Command and Readout Responder

This block is the target side of a two-wire serial bus for a twelve-bit sampling converter. It watches the clock and data lines through synchronisers and recognises start, repeated-start and stop conditions. It answers only its own seven-bit address, which is a fixed five-bit prefix followed by two strap inputs. A write transfer delivers one command byte. The block acknowledges that byte, latches the channel, input-mode and power-mode fields from it, and asks the converter front end for a sample. A read transfer returns the latched result as two bytes.

The usual sequence is a write of the address and command byte, then a repeated start, then a read of the address and two data bytes, closed by a not-acknowledge and a stop. The command survives the repeated start and the stop, so a later read returns the same result again. The block pulls the data line low only while the clock is low. Its data output is an active-high pull-down enable for an open-drain pad.

Top module: `i2c_adc_responder`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal binary 10010 followed by `strap[1]` and `strap[0]`. Bit 0 of that byte selects the direction (0 write, 1 read). For any other address it leaves the data line released for the rest of the transfer.
- R2: In a write transfer the first byte after the address is acknowledged and decoded. Bit 7 drives `cfg_single`, bits 6..4 drive `cfg_chan`, bits 3..2 drive `cfg_pwr`, and bits 1..0 are ignored.
- R3: The decoded fields keep their values until the next accepted command byte, across repeated starts and stops.
- R4: Each accepted command byte produces exactly one single-cycle `sample_req` pulse. `sample_data` is captured into the result register in that cycle.
- R5: A read returns first a byte of four zero bits followed by result bits 11..8, and then a byte holding result bits 7..0. Each byte is sent MSB first.
- R6: The second byte is sent only after the master acknowledges the first. A read that follows no command returns the last captured result, or zero after reset.
- R7: At the end of the second read byte, `read_nacked` becomes 1 if the master answered with a not-acknowledge and 0 if it answered with an acknowledge. In both cases the block then releases the data line.
- R8: `sda_pull` changes only while the synchronised clock is low, and it is 0 during every bit the master drives, including the master's acknowledge bit.
- R9: A start condition at any point restarts the address phase. A stop condition at any point returns the block to idle, and a partly received command byte has no effect.
- R10: After reset `sda_pull`, `sample_req`, `read_nacked` and all decoded fields are 0.
- R11: A further byte written after the command byte in the same transfer is not acknowledged and does not change the fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line level (asynchronous) |
| sda_in | input | 1 | Bus data line level (asynchronous) |
| strap | input | 2 | Address strap bits, low two address bits |
| sample_data | input | 12 | Parallel conversion result from the front end |
| sda_pull | output | 1 | 1 pulls the data line low, 0 releases it |
| sample_req | output | 1 | One-cycle request for a new sample |
| cfg_single | output | 1 | Input-mode flag from the command byte |
| cfg_chan | output | 3 | Channel select from the command byte |
| cfg_pwr | output | 2 | Power-mode field from the command byte |
| read_nacked | output | 1 | Last read ended with a master not-acknowledge |

## Verification
The hardest states to reach are a start or stop condition that arrives part way through a byte, and a read that arrives with no command before it. Both of them cut across the normal command-then-read flow. The bench drives the bus bit by bit with its own tasks. It can therefore stop after any number of bits and then issue a repeated start or a stop. It also performs a read straight after reset and a read after a completed command, each time with a different value on the sample input. Field values and read-back bytes are compared against the command and sample values in the vector table.

// File: rtl/i2c_adc_pkg.sv
package i2c_adc_pkg;

  localparam int BYTE_W = 8;
  localparam int CODE_W = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_CMD,
    ST_CMD_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_SKIP
  } bus_state_t;

  typedef struct packed {
    logic       single;
    logic [2:0] chan;
    logic [1:0] pwr;
  } cmd_fields_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_q;
  logic              sda_q;

  // synchroniser chain, one flop per stage, idle-high reset
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_pipe[0] <= 1'b1;
          sda_pipe[0] <= 1'b1;
        end else begin
          scl_pipe[0] <= scl_in;
          sda_pipe[0] <= sda_in;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_pipe[g] <= 1'b1;
          sda_pipe[g] <= 1'b1;
        end else begin
          scl_pipe[g] <= scl_pipe[g-1];
          sda_pipe[g] <= sda_pipe[g-1];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_lvl;
      sda_q <= sda_lvl;
    end
  end

  assign scl_lvl   = scl_pipe[STAGES-1];
  assign sda_lvl   = sda_pipe[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_q;
  assign scl_fall  = ~scl_lvl & scl_q;
  assign start_det = scl_lvl & scl_q & sda_q & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_q & ~sda_q & sda_lvl;

endmodule

// File: rtl/i2c_adc_cmd_bank.sv
module i2c_adc_cmd_bank
  import i2c_adc_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_load,
  input  logic [CODE_W-1:0] cmd_code,
  input  logic [DATA_W-1:0] sample_data,
  output cmd_fields_t       fields,
  output logic              sample_req,
  output logic [DATA_W-1:0] result
);

  always_ff @(posedge clk) begin
    if (rst) begin
      fields     <= '0;
      sample_req <= 1'b0;
      result     <= '0;
    end else begin
      sample_req <= cmd_load;
      if (cmd_load) begin
        fields <= cmd_code;
      end
      if (sample_req) begin
        result <= sample_data;
      end
    end
  end

  // R4: the request is a lone one-cycle pulse
  p_req_single_r4: assert property (@(posedge clk) disable iff (rst)
    sample_req |=> !sample_req);

  // R3: fields move only when the protocol engine loads a command
  p_fields_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !cmd_load |=> $stable(fields));

  // R6: the readout value changes only on a sample request
  p_result_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !sample_req |=> $stable(result));

endmodule

// File: rtl/i2c_adc_fsm.sv
module i2c_adc_fsm
  import i2c_adc_pkg::*;
#(
  parameter int                PREFIX_W    = 5,
  parameter logic [PREFIX_W-1:0] ADDR_PREFIX = 5'b10010,
  parameter int                STRAP_W     = 2,
  parameter int                DATA_W      = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_lvl,
  input  logic               sda_lvl,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_det,
  input  logic               stop_det,
  input  logic [STRAP_W-1:0] strap,
  input  logic [DATA_W-1:0]  result,
  output logic               sda_pull,
  output logic               cmd_load,
  output logic [CODE_W-1:0]  cmd_code,
  output logic               read_nacked
);

  localparam int ADDR_W  = PREFIX_W + STRAP_W;
  localparam int FRAME_W = 2 * BYTE_W;
  localparam int PAD_W   = FRAME_W - DATA_W;

  bus_state_t        state;
  logic [2:0]        bit_cnt;
  logic              byte_full;
  logic [BYTE_W-1:0] rx_sh;
  logic [BYTE_W-1:0] tx_sh;
  logic              rd_dir;
  logic              tx_second;
  logic              ack_seen;
  logic              addr_hit;
  logic [FRAME_W-1:0] frame;

  assign addr_hit = (rx_sh[BYTE_W-1 -: ADDR_W] == {ADDR_PREFIX, strap});
  assign frame    = {{PAD_W{1'b0}}, result};

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      bit_cnt     <= '0;
      byte_full   <= 1'b0;
      rx_sh       <= '0;
      tx_sh       <= '0;
      rd_dir      <= 1'b0;
      tx_second   <= 1'b0;
      ack_seen    <= 1'b0;
      sda_pull    <= 1'b0;
      cmd_load    <= 1'b0;
      cmd_code    <= '0;
      read_nacked <= 1'b0;
    end else begin
      cmd_load <= 1'b0;
      if (start_det) begin
        state     <= ST_ADDR;
        bit_cnt   <= '0;
        byte_full <= 1'b0;
        sda_pull  <= 1'b0;
      end else if (stop_det) begin
        state     <= ST_IDLE;
        byte_full <= 1'b0;
        sda_pull  <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_CMD: begin
            if (scl_rise) begin
              rx_sh   <= {rx_sh[BYTE_W-2:0], sda_lvl};
              bit_cnt <= bit_cnt + 3'd1;
              if (bit_cnt == 3'd7) byte_full <= 1'b1;
            end
            if (scl_fall && byte_full) begin
              byte_full <= 1'b0;
              if (state == ST_ADDR) begin
                if (addr_hit) begin
                  rd_dir   <= rx_sh[0];
                  state    <= ST_ADDR_ACK;
                  sda_pull <= 1'b1;
                end else begin
                  state <= ST_SKIP;
                end
              end else begin
                cmd_code <= rx_sh[BYTE_W-1 -: CODE_W];
                state    <= ST_CMD_ACK;
                sda_pull <= 1'b1;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              bit_cnt <= '0;
              if (rd_dir) begin
                tx_second <= 1'b0;
                tx_sh     <= frame[FRAME_W-1 -: BYTE_W];
                sda_pull  <= ~frame[FRAME_W-1];
                state     <= ST_TX;
              end else begin
                sda_pull <= 1'b0;
                state    <= ST_CMD;
              end
            end
          end
          ST_CMD_ACK: begin
            if (scl_fall) begin
              sda_pull <= 1'b0;
              cmd_load <= 1'b1;
              state    <= ST_SKIP;
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              bit_cnt <= bit_cnt + 3'd1;
              if (bit_cnt == 3'd7) begin
                sda_pull <= 1'b0;
                state    <= ST_TX_ACK;
              end else begin
                tx_sh    <= {tx_sh[BYTE_W-2:0], 1'b0};
                sda_pull <= ~tx_sh[BYTE_W-2];
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) ack_seen <= ~sda_lvl;
            if (scl_fall) begin
              if (!tx_second) begin
                if (ack_seen) begin
                  tx_second <= 1'b1;
                  tx_sh     <= frame[BYTE_W-1:0];
                  sda_pull  <= ~frame[BYTE_W-1];
                  bit_cnt   <= '0;
                  state     <= ST_TX;
                end else begin
                  state <= ST_SKIP;
                end
              end else begin
                read_nacked <= ~ack_seen;
                state       <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R8: the pull-down only moves while the clock line is low
  p_pull_scl_low_r8: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_pull) |-> !scl_lvl);

  // R8: the pull-down is only active in acknowledge or transmit phases
  p_pull_states_r8: assert property (@(posedge clk) disable iff (rst)
    sda_pull |-> (state == ST_ADDR_ACK || state == ST_CMD_ACK || state == ST_TX));

  // R1: an address acknowledge follows only a matching address
  p_ack_match_r1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ADDR_ACK && $past(state) == ST_ADDR) |-> $past(addr_hit));

  // R4: a command load follows only the command acknowledge bit
  p_load_after_ack_r4: assert property (@(posedge clk) disable iff (rst)
    cmd_load |-> $past(state) == ST_CMD_ACK);

  // R7: the end-of-read flag changes only after the second byte
  p_nack_update_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(read_nacked) |-> ($past(state) == ST_TX_ACK && $past(tx_second)));

endmodule

// File: rtl/i2c_adc_responder.sv
module i2c_adc_responder
  import i2c_adc_pkg::*;
#(
  parameter int                  DATA_W      = 12,
  parameter int                  PREFIX_W    = 5,
  parameter logic [PREFIX_W-1:0] ADDR_PREFIX = 5'b10010,
  parameter int                  STRAP_W     = 2,
  parameter int                  SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_in,
  input  logic               sda_in,
  input  logic [STRAP_W-1:0] strap,
  input  logic [DATA_W-1:0]  sample_data,
  output logic               sda_pull,
  output logic               sample_req,
  output logic               cfg_single,
  output logic [2:0]         cfg_chan,
  output logic [1:0]         cfg_pwr,
  output logic               read_nacked
);

  logic              scl_lvl;
  logic              sda_lvl;
  logic              scl_rise;
  logic              scl_fall;
  logic              start_det;
  logic              stop_det;
  logic              cmd_load;
  logic [CODE_W-1:0] cmd_code;
  logic [DATA_W-1:0] result;
  cmd_fields_t       fields;

  i2c_line_sync #(
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst      (rst),
    .scl_in   (scl_in),
    .sda_in   (sda_in),
    .scl_lvl  (scl_lvl),
    .sda_lvl  (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  i2c_adc_fsm #(
    .PREFIX_W   (PREFIX_W),
    .ADDR_PREFIX(ADDR_PREFIX),
    .STRAP_W    (STRAP_W),
    .DATA_W     (DATA_W)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .scl_lvl    (scl_lvl),
    .sda_lvl    (sda_lvl),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .strap      (strap),
    .result     (result),
    .sda_pull   (sda_pull),
    .cmd_load   (cmd_load),
    .cmd_code   (cmd_code),
    .read_nacked(read_nacked)
  );

  i2c_adc_cmd_bank #(
    .DATA_W(DATA_W)
  ) u_bank (
    .clk        (clk),
    .rst        (rst),
    .cmd_load   (cmd_load),
    .cmd_code   (cmd_code),
    .sample_data(sample_data),
    .fields     (fields),
    .sample_req (sample_req),
    .result     (result)
  );

  assign cfg_single = fields.single;
  assign cfg_chan   = fields.chan;
  assign cfg_pwr    = fields.pwr;

endmodule

// File: tb/sim_i2c_adc_responder.sv
module sim_i2c_adc_responder;

  localparam int Q  = 6;
  localparam int WD = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic [1:0]  strap = 2'b00;
  logic [11:0] sample_data = '0;
  logic        sda_pull, sample_req, cfg_single, read_nacked;
  logic [2:0]  cfg_chan;
  logic [1:0]  cfg_pwr;
  logic        line;

  int checks = 0;
  int fails  = 0;
  int req_cnt = 0;
  bit done = 0;

  assign line = sda_m & ~sda_pull;

  always #4 clk = ~clk;

  i2c_adc_responder u0 (
    .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(line), .strap(strap),
    .sample_data(sample_data), .sda_pull(sda_pull), .sample_req(sample_req),
    .cfg_single(cfg_single), .cfg_chan(cfg_chan), .cfg_pwr(cfg_pwr),
    .read_nacked(read_nacked)
  );

  always @(posedge clk) if (!rst && sample_req) req_cnt <= req_cnt + 1;

  // strap(2) | command(8) | sample(12)
  localparam logic [21:0] VEC [4] = '{
    {2'b00, 8'b1010_1100, 12'hA5C},
    {2'b01, 8'b0111_0001, 12'h3F0},
    {2'b10, 8'b1001_0111, 12'h0FF},
    {2'b11, 8'b0000_1010, 12'hFFF}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; tick(Q);
    scl_m = 1'b1; tick(2*Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    b = line; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic acked);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(a);
    acked = ~a;
  endtask

  task automatic recv_byte(input logic m_ack, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      logic b;
      get_bit(b);
      v[i] = b;
    end
    sda_m = ~m_ack; tick(Q);
    scl_m = 1'b1; tick(Q);
    check(sda_pull == 1'b0, "R8 released in master ack bit", sda_pull, 0);
    tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic read_pair(input logic [6:0] a7, input logic last_ack,
                           output logic ak, output logic [7:0] hi, output logic [7:0] lo);
    bus_start();
    send_byte({a7, 1'b1}, ak);
    recv_byte(1'b1, hi);
    recv_byte(last_ack, lo);
    bus_stop();
  endtask

  initial begin : watchdog
    repeat (WD) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      report();
      $finish;
    end
  end

  initial begin : main
    logic ak, ak2;
    logic [7:0] hi, lo;
    int c0;
    tick(10);
    rst = 1'b0;
    tick(2);

    // R10 reset state
    check(sda_pull == 0 && sample_req == 0 && read_nacked == 0, "R10 reset outputs",
          {sda_pull, sample_req, read_nacked}, 0);
    check({cfg_single, cfg_chan, cfg_pwr} == 6'd0, "R10 reset fields",
          {cfg_single, cfg_chan, cfg_pwr}, 0);

    // R6 read with no command after reset returns zero
    sample_data = 12'h777;
    read_pair({5'b10010, 2'b00}, 1'b0, ak, hi, lo);
    check(ak, "R1 read address ack", ak, 1);
    check(hi == 8'h00 && lo == 8'h00, "R6 read before command", {hi, lo}, 0);
    check(read_nacked == 1'b1, "R7 nack after second byte", read_nacked, 1);

    // vector table: command, repeated start, read
    for (int k = 0; k < 4; k++) begin
      logic [21:0] v;
      v = VEC[k];
      strap = v[21:20];
      sample_data = v[11:0];
      c0 = req_cnt;
      bus_start();
      send_byte({5'b10010, v[21:20], 1'b0}, ak);
      check(ak, "R1 write address ack", ak, 1);
      send_byte(v[19:12], ak2);
      check(ak2, "R2 command ack", ak2, 1);
      check({cfg_single, cfg_chan, cfg_pwr} == v[19:14], "R2 decoded fields",
            {cfg_single, cfg_chan, cfg_pwr}, v[19:14]);
      check(req_cnt == c0 + 1, "R4 one request per command", req_cnt, c0 + 1);
      read_pair({5'b10010, v[21:20]}, 1'b0, ak, hi, lo);
      check(ak, "R1 read address ack after Sr", ak, 1);
      check({cfg_single, cfg_chan, cfg_pwr} == v[19:14], "R3 fields kept across Sr",
            {cfg_single, cfg_chan, cfg_pwr}, v[19:14]);
      check(hi == {4'b0000, v[11:8]}, "R5 first byte", hi, {4'b0000, v[11:8]});
      check(lo == v[7:0], "R5 second byte", lo, v[7:0]);
      check(read_nacked == 1'b1, "R7 nack flag", read_nacked, 1);
    end

    // R1 wrong strap and wrong prefix are ignored (strap now 11)
    c0 = req_cnt;
    bus_start();
    send_byte({5'b10010, 2'b01, 1'b0}, ak);
    check(!ak, "R1 strap mismatch not acked", ak, 0);
    send_byte(8'hFF, ak2);
    check(!ak2, "R1 no ack after mismatch", ak2, 0);
    bus_stop();
    bus_start();
    send_byte({5'b10011, 2'b11, 1'b0}, ak);
    check(!ak, "R1 prefix mismatch not acked", ak, 0);
    bus_stop();
    check({cfg_single, cfg_chan, cfg_pwr} == 6'b000010 && req_cnt == c0,
          "R1 fields unchanged after mismatch", {cfg_single, cfg_chan, cfg_pwr}, 6'b000010);

    // R11 extra write byte not acked; R3 fields kept over stop
    sample_data = 12'hB2E;
    bus_start();
    send_byte({5'b10010, 2'b11, 1'b0}, ak);
    send_byte(8'b1100_0000, ak);
    check(ak, "R2 command ack", ak, 1);
    send_byte(8'b0011_1111, ak2);
    check(!ak2, "R11 extra byte not acked", ak2, 0);
    bus_stop();
    check({cfg_single, cfg_chan, cfg_pwr} == 6'b110000, "R11 fields after extra byte",
          {cfg_single, cfg_chan, cfg_pwr}, 6'b110000);

    // R6 read without new command returns last result; R7 ack clears flag
    sample_data = 12'h123;
    read_pair({5'b10010, 2'b11}, 1'b1, ak, hi, lo);
    check(hi == 8'h0B && lo == 8'h2E, "R6 last result reread", {hi, lo}, 16'h0B2E);
    check(read_nacked == 1'b0, "R7 ack clears flag", read_nacked, 0);
    check({cfg_single, cfg_chan, cfg_pwr} == 6'b110000, "R3 fields kept over stop",
          {cfg_single, cfg_chan, cfg_pwr}, 6'b110000);

    // R9 start part way through an address byte
    bus_start();
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b0);
    bus_start();
    send_byte({5'b10010, 2'b11, 1'b0}, ak);
    check(ak, "R9 restart after partial byte", ak, 1);
    send_byte(8'b0011_1000, ak2);
    bus_stop();
    check({cfg_single, cfg_chan, cfg_pwr} == 6'b001110, "R9 command after restart",
          {cfg_single, cfg_chan, cfg_pwr}, 6'b001110);

    // R9 stop part way through a command byte
    c0 = req_cnt;
    bus_start();
    send_byte({5'b10010, 2'b11, 1'b0}, ak);
    put_bit(1'b1); put_bit(1'b1); put_bit(1'b1); put_bit(1'b1);
    bus_stop();
    check({cfg_single, cfg_chan, cfg_pwr} == 6'b001110 && req_cnt == c0,
          "R9 partial command dropped", {cfg_single, cfg_chan, cfg_pwr}, 6'b001110);
    check(sda_pull == 1'b0, "R9 idle after stop", sda_pull, 0);

    done = 1;
    report();
    $finish;
  end

endmodule